// File: doc/BRIEF.md
# Interrupt Acknowledge Hold Gate

This block sits beside a simple in-order CPU core. At each instruction boundary it decides whether a pending maskable interrupt may be taken. It holds the request flags, the mask bits and the interrupt-enable flag. The core reports the end of each instruction on a strobe, together with a 3-bit class code for the instruction that just completed.

Some instructions touch the status word, the enable state, or the flag, mask or priority registers. The decoder marks these as hold-class. At the end of a hold-class instruction no interrupt is taken, so the earliest acknowledge comes at the end of the next non-hold instruction.

A software break is not hold-class. It does clear the enable flag, so a maskable request that arrives during a break is not taken.

When an interrupt is granted, the block emits a one-clock acknowledge pulse, the index of the winning source and a save-and-jump request. At the same time it clears the winner's flag and the enable flag. The core then saves the status word and program counter and fetches from the service vector.

When several requests compete, the lowest index wins.

Top module: `intr_ack_gate`

## Requirements
- R1: A synchronous active-high reset clears the enable flag and all request flags, sets every mask bit and keeps the acknowledge low.
- R2: An acknowledge is registered at the clock edge where all of the following hold:
  - the instruction strobe is high;
  - the class code is 0 (plain) or one of the unassigned codes 5, 6 or 7;
  - the enable flag is 1;
  - some request flag is set with its mask bit clear.
  
  `ack_o`, `save_jump_o` and `ack_id_o` then show the grant in the following cycle.
- R3: At the end of a hold-class instruction no acknowledge is produced. The hold-class codes are 1 (generic status, flag, mask or priority access), 2 (enable interrupts) and 3 (disable interrupts).
- R4: The hold does not accumulate. After a run of consecutive hold-class instructions, the first acknowledge comes at the end of the first non-hold instruction.
- R5: Class code 4 (software break) is not hold-class. It produces no acknowledge at its own boundary, and it clears the enable flag.
- R6: A completed code-2 instruction sets the enable flag, and a completed code-3 instruction clears it. The new value appears on `ie_o` the cycle after the strobe.
- R7: Among eligible requests, the one with the lowest index is granted.
- R8: The acknowledge lasts exactly one clock. In the same cycle, the granted source's flag and the enable flag read 0.
- R9: A request whose mask bit is 1 is never granted. Asserting the mask write enable replaces the whole mask with the write data at the next edge.
- R10: Bits of `irq_set_i` are ORed into the request flags at each edge. When a set and an acknowledge hit the same bit at the same edge, the set wins.
- R11: While the instruction strobe is low, no acknowledge is produced and the enable flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_done_i | input | 1 | End-of-instruction strobe |
| instr_cls_i | input | 3 | Class code of the completed instruction |
| irq_set_i | input | N_SRC | Per-source request set pulses |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wd_i | input | N_SRC | Mask write data (1 = masked) |
| ack_o | output | 1 | Acknowledge pulse |
| ack_id_o | output | ID_W | Index of the granted source |
| save_jump_o | output | 1 | Request to save status word and PC and jump to the service vector |
| ie_o | output | 1 | Interrupt-enable flag |
| pend_o | output | N_SRC | Request flags |

## Verification
Every result of this block is registered once. The acknowledge, the source index, the save request, the enable flag and the request flags all reflect a strobe at the first clock edge after it is driven.

The bench drives each stimulus half a period before an edge and compares all outputs half a period after that edge. It uses a bench model that advances one step per edge.

Directed sequences place hold-class runs, breaks and set/acknowledge collisions on exact boundaries. Seeded random sequences then exercise class mixes and mask writes under the same one-edge latency.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;

   localparam logic [2:0] CLS_PLAIN = 3'd0;
   localparam logic [2:0] CLS_HOLD  = 3'd1;
   localparam logic [2:0] CLS_EN    = 3'd2;
   localparam logic [2:0] CLS_DIS   = 3'd3;
   localparam logic [2:0] CLS_BRK   = 3'd4;

   function automatic logic cls_is_hold(input logic [2:0] c);
      return (c == CLS_HOLD) || (c == CLS_EN) || (c == CLS_DIS);
   endfunction

endpackage

// File: rtl/intr_cls_decode.sv
module intr_cls_decode
   import intr_gate_pkg::*;
(
   input  logic       done_i,
   input  logic [2:0] cls_i,
   output logic       bound_ok_o,
   output logic       ie_set_o,
   output logic       ie_clr_o
);

   logic hold_w;
   logic brk_w;

   always_comb begin
      hold_w     = cls_is_hold(cls_i);
      brk_w      = (cls_i == CLS_BRK);
      bound_ok_o = done_i && !hold_w && !brk_w;
      ie_set_o   = done_i && (cls_i == CLS_EN);
      ie_clr_o   = done_i && ((cls_i == CLS_DIS) || brk_w);
   end

endmodule

// File: rtl/intr_req_bank.sv
module intr_req_bank #(
   parameter int N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   input  logic             mask_we_i,
   input  logic [N_SRC-1:0] mask_wd_i,
   output logic [N_SRC-1:0] pend_o,
   output logic [N_SRC-1:0] mask_o
);

   for (genvar g = 0; g < N_SRC; g++) begin : g_bit
      logic pend_q;
      logic mask_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            pend_q <= 1'b0;
            mask_q <= 1'b1;
         end else begin
            pend_q <= (pend_q && !clr_i[g]) || set_i[g];
            if (mask_we_i) mask_q <= mask_wd_i[g];
         end
      end

      assign pend_o[g] = pend_q;
      assign mask_o[g] = mask_q;
   end

   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(clr_i)); // R8
   AST_CLR_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
      ((clr_i & ~pend_o) == '0)); // R8

endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
   parameter int N_SRC      = 16,
   parameter int PICK_STYLE = 0,
   localparam int ID_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] req_i,
   output logic [N_SRC-1:0] grant_o,
   output logic [ID_W-1:0]  id_o,
   output logic             any_o
);

   if (PICK_STYLE == 0) begin : g_chain
      logic [N_SRC:0] seen;
      assign seen[0] = 1'b0;
      for (genvar g = 0; g < N_SRC; g++) begin : g_stage
         assign grant_o[g]  = req_i[g] && !seen[g];
         assign seen[g+1]   = seen[g] || req_i[g];
      end
   end else begin : g_isolate
      logic [N_SRC-1:0] neg_w;
      assign neg_w   = ~req_i + {{(N_SRC-1){1'b0}}, 1'b1};
      assign grant_o = req_i & neg_w;
   end

   always_comb begin
      id_o = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (grant_o[i]) id_o = id_o | ID_W'(i);
      end
   end

   assign any_o = |req_i;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_o)); // R7
   AST_GRANT_IF_ANY: assert property (@(posedge clk) disable iff (rst)
      any_o |-> ($countones(grant_o) == 1)); // R7
   AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
      ((grant_o & ~req_i) == '0)); // R9

endmodule

// File: rtl/intr_ack_gate.sv
module intr_ack_gate
   import intr_gate_pkg::*;
#(
   parameter int N_SRC      = 16,
   parameter int PICK_STYLE = 0,
   localparam int ID_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             instr_done_i,
   input  logic [2:0]       instr_cls_i,
   input  logic [N_SRC-1:0] irq_set_i,
   input  logic             mask_we_i,
   input  logic [N_SRC-1:0] mask_wd_i,
   output logic             ack_o,
   output logic [ID_W-1:0]  ack_id_o,
   output logic             save_jump_o,
   output logic             ie_o,
   output logic [N_SRC-1:0] pend_o
);

   if (N_SRC < 2 || N_SRC > 64) begin : g_bad_width
      $error("intr_ack_gate: N_SRC must lie in 2..64");
   end
   if (PICK_STYLE != 0 && PICK_STYLE != 1) begin : g_bad_style
      $error("intr_ack_gate: PICK_STYLE must be 0 or 1");
   end

   logic             bound_ok;
   logic             ie_set;
   logic             ie_clr;
   logic [N_SRC-1:0] mask_w;
   logic [N_SRC-1:0] elig_w;
   logic [N_SRC-1:0] grant_w;
   logic [N_SRC-1:0] clr_w;
   logic [ID_W-1:0]  gid_w;
   logic             any_w;
   logic             take_w;
   logic             ie_q;
   logic             ack_q;
   logic [ID_W-1:0]  id_q;

   intr_cls_decode i_dec (
      .done_i     (instr_done_i),
      .cls_i      (instr_cls_i),
      .bound_ok_o (bound_ok),
      .ie_set_o   (ie_set),
      .ie_clr_o   (ie_clr)
   );

   assign elig_w = pend_o & ~mask_w;

   intr_prio_pick #(
      .N_SRC      (N_SRC),
      .PICK_STYLE (PICK_STYLE)
   ) i_pick (
      .clk     (clk),
      .rst     (rst),
      .req_i   (elig_w),
      .grant_o (grant_w),
      .id_o    (gid_w),
      .any_o   (any_w)
   );

   assign take_w = bound_ok && ie_q && any_w;
   assign clr_w  = take_w ? grant_w : '0;

   intr_req_bank #(
      .N_SRC (N_SRC)
   ) i_bank (
      .clk       (clk),
      .rst       (rst),
      .set_i     (irq_set_i),
      .clr_i     (clr_w),
      .mask_we_i (mask_we_i),
      .mask_wd_i (mask_wd_i),
      .pend_o    (pend_o),
      .mask_o    (mask_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ie_q  <= 1'b0;
         ack_q <= 1'b0;
         id_q  <= '0;
      end else begin
         ack_q <= take_w;
         if (take_w) id_q <= gid_w;
         if (take_w)      ie_q <= 1'b0;
         else if (ie_set) ie_q <= 1'b1;
         else if (ie_clr) ie_q <= 1'b0;
      end
   end

   assign ack_o       = ack_q;
   assign save_jump_o = ack_q;
   assign ack_id_o    = id_q;
   assign ie_o        = ie_q;

   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
      ack_o |=> !ack_o); // R8
   AST_ACK_DROPS_IE: assert property (@(posedge clk) disable iff (rst)
      ack_o |-> !ie_o); // R8
   AST_HOLD_DEFERS: assert property (@(posedge clk) disable iff (rst)
      (instr_done_i && cls_is_hold(instr_cls_i)) |=> !ack_o); // R3
   AST_BRK_NO_ACK: assert property (@(posedge clk) disable iff (rst)
      (instr_done_i && instr_cls_i == CLS_BRK) |=> (!ack_o && !ie_o)); // R5
   AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
      !instr_done_i |=> (!ack_o && $stable(ie_o))); // R11
   AST_ACK_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
      (!ie_o && !instr_done_i) |=> !ack_o); // R2
   AST_EN_SETS_IE: assert property (@(posedge clk) disable iff (rst)
      (instr_done_i && instr_cls_i == CLS_EN) |=> ie_o); // R6

endmodule

// File: tb/test_intr_ack_gate.sv
module test_intr_ack_gate;

   localparam int N     = 16;
   localparam int IDW   = $clog2(N);
   localparam int T_CLK = 10;

   logic           clk = 1'b0;
   logic           rst;
   logic           done;
   logic [2:0]     cls;
   logic [N-1:0]   set;
   logic           mwe;
   logic [N-1:0]   mwd;
   logic           ack;
   logic [IDW-1:0] ack_id;
   logic           sj;
   logic           ie;
   logic [N-1:0]   pend;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic           m_ie;
   logic [N-1:0]   m_pend;
   logic [N-1:0]   m_mask;
   logic           m_ack;
   logic [IDW-1:0] m_id;

   always #(T_CLK/2) clk = ~clk;

   intr_ack_gate #(.N_SRC(N)) i_intr_ack_gate (
      .clk          (clk),
      .rst          (rst),
      .instr_done_i (done),
      .instr_cls_i  (cls),
      .irq_set_i    (set),
      .mask_we_i    (mwe),
      .mask_wd_i    (mwd),
      .ack_o        (ack),
      .ack_id_o     (ack_id),
      .save_jump_o  (sj),
      .ie_o         (ie),
      .pend_o       (pend)
   );

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic is_hold(input logic [2:0] c);
      return (c == 3'd1) || (c == 3'd2) || (c == 3'd3);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input string req, input logic d, input logic [2:0] c,
                       input logic [N-1:0] s, input logic we,
                       input logic [N-1:0] wd);
      logic [N-1:0] elig;
      logic         grant;
      int           w;
      done = d; cls = c; set = s; mwe = we; mwd = wd;
      elig  = m_pend & ~m_mask;
      grant = d && !is_hold(c) && (c != 3'd4) && m_ie && (elig != '0);
      w     = lowest(elig);
      m_ack = grant;
      if (grant) m_id = IDW'(w);
      if (grant)                 m_ie = 1'b0;
      else if (d && c == 3'd2)   m_ie = 1'b1;
      else if (d && (c == 3'd3 || c == 3'd4)) m_ie = 1'b0;
      if (grant) m_pend[w] = 1'b0;
      m_pend = m_pend | s;
      if (we) m_mask = wd;
      @(posedge clk);
      @(negedge clk);
      check(req, "ack", 32'(ack), 32'(m_ack));
      check(req, "save_jump", 32'(sj), 32'(m_ack));
      if (m_ack) check(req, "ack_id", 32'(ack_id), 32'(m_id));
      check(req, "ie", 32'(ie), 32'(m_ie));
      check(req, "pend", 32'(pend), 32'(m_pend));
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst = 1'b1; done = 1'b0; cls = '0; set = '0; mwe = 1'b0; mwd = '0;
      m_ie = 1'b0; m_pend = '0; m_mask = '1; m_ack = 1'b0; m_id = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check("R1", "ack", 32'(ack), 32'd0);
      check("R1", "ie", 32'(ie), 32'd0);
      check("R1", "pend", 32'(pend), 32'd0);
      step("R6", 1'b1, 3'd2, '0, 1'b0, '0);
      step("R11", 1'b0, 3'd0, N'(1 << 3), 1'b0, '0);
      // R1/R9: mask all ones after reset, no grant
      step("R9", 1'b1, 3'd0, '0, 1'b0, '0);
      step("R9", 1'b0, 3'd0, '0, 1'b1, '0);
      step("R2", 1'b1, 3'd0, '0, 1'b0, '0);
      step("R8", 1'b0, 3'd0, '0, 1'b0, '0);
      step("R8", 1'b1, 3'd0, '0, 1'b0, '0);
      // R3 and R7
      step("R3", 1'b1, 3'd2, N'((1 << 5) | (1 << 9)), 1'b0, '0);
      step("R7", 1'b1, 3'd0, '0, 1'b0, '0);
      // R4 back-to-back hold
      step("R4", 1'b1, 3'd2, '0, 1'b0, '0);
      step("R4", 1'b1, 3'd1, '0, 1'b0, '0);
      step("R4", 1'b1, 3'd3, '0, 1'b0, '0);
      step("R4", 1'b1, 3'd2, '0, 1'b0, '0);
      step("R4", 1'b1, 3'd1, '0, 1'b0, '0);
      step("R4", 1'b1, 3'd0, '0, 1'b0, '0);
      // R5 break
      step("R5", 1'b1, 3'd2, '0, 1'b0, '0);
      step("R5", 1'b1, 3'd4, N'(1 << 2), 1'b0, '0);
      step("R5", 1'b1, 3'd0, '0, 1'b0, '0);
      // R6 disable
      step("R6", 1'b1, 3'd2, '0, 1'b0, '0);
      step("R6", 1'b1, 3'd3, '0, 1'b0, '0);
      step("R6", 1'b1, 3'd0, '0, 1'b0, '0);
      // R2 unassigned code acts as plain
      step("R2", 1'b1, 3'd2, '0, 1'b0, '0);
      step("R2", 1'b1, 3'd6, '0, 1'b0, '0);
      // R10 set wins over clear
      step("R10", 1'b1, 3'd2, N'(1), 1'b0, '0);
      step("R10", 1'b1, 3'd0, N'(1), 1'b0, '0);
      // R9 masked lower source loses to unmasked higher
      step("R9", 1'b1, 3'd2, N'(1 << 12), 1'b1, N'(1));
      step("R9", 1'b1, 3'd0, '0, 1'b0, '0);
      // seeded random mix
      for (int k = 0; k < 3000; k++) begin
         logic [2:0]   c;
         logic [N-1:0] s;
         logic [N-1:0] wd;
         int           r;
         r  = int'($urandom_range(0, 9));
         c  = (r < 4) ? 3'd0 : (r < 8) ? 3'($urandom_range(1, 3))
                       : 3'($urandom_range(4, 7));
         s  = ($urandom_range(0, 3) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
         wd = N'($urandom) & N'($urandom);
         step("R2", 1'($urandom_range(0, 1)), c, s,
              $urandom_range(0, 15) == 0, wd);
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule